// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Readback Freeze

This block keeps the time of day and the calendar date as packed-BCD counters: seconds, minutes, hours, day of week, day of month, month, a two-digit year and a separate century byte that carries the year past 99. Each single-cycle pulse on `tick` advances the time by one second. Month lengths and the leap-year rule, including the century exception, decide when the day of month wraps.

A host reaches the block over a byte-wide register port. Writes take one cycle. Reads are combinational from the address. A transfer-enable bit in the control byte selects what the host sees. While the bit is set, reads return the running counters. Clearing the bit captures a snapshot, and reads then return that snapshot while the counters keep running. The host may overwrite fields of the snapshot while the bit is clear. Setting the bit again loads the edited snapshot into the counters as the new time. If no field was written, the counters are left alone and no second is lost.

Top module: `bcd_timekeeper`

## Requirements
- R1: While reset is held and just after it, transfer enable reads as 1, and the time registers read the reset time given by the parameters. The control byte at address 0xF reads 0x80 in this state.
- R2: Each tick advances seconds in BCD from 00 to 59. Seconds then wrap to 00 and carry into minutes. Minutes run 00 to 59 and carry into hours.
- R3: Hours run 00 to 23 and wrap to 00. That wrap advances day of week, which counts 1 to 7 and returns to 1, and also advances day of month.
- R4: Day of month wraps to 01 after its last day: 30 for months 04, 06, 09 and 11, and 31 for the other months apart from February. That wrap advances the month, and a month wrap from 12 to 01 advances the year.
- R5: February ends on day 29 when the full year is divisible by 4. The exception is a year of 00, where the century must also be divisible by 4. Otherwise February ends on day 28.
- R6: A year wrap from 99 to 00 increments the century in BCD, and the century wraps from 99 to 00.
- R7: Writing the control byte with bit 7 = 0 while transfer enable is 1 captures the current counters as the snapshot, and reads then return the snapshot. Ticks keep advancing the hidden counters. Setting bit 7 again without any field write shows the running time with no tick lost.
- R8: While transfer enable is 0, a write to address 0x0 to 0x7 stores that field with its mask. Seconds and minutes keep bits 6:0. Hours and day of month keep bits 5:0. Month keeps bits 4:0. Day of week keeps bits 2:0. Year and century keep all eight bits. Month bits 7:5 are never changed by a write and read as 0.
- R9: Writing bit 7 = 1 to the control byte while transfer enable is 0, after at least one field write since the freeze, loads the whole snapshot into the counters. A tick in that same cycle is applied on top of the loaded time.
- R10: While transfer enable is 1, writes to the time addresses are ignored. Addresses 0x8 to 0xE read 0x00, and bits 6:0 of the control byte read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |

## Verification
The bench builds the block with a reset time of 1999-12-31 23:59:50, with the day of week at 7. The first ten ticks therefore carry through every field at once: the day of week returns to 1, the month and year wrap, and the century goes from 19 to 20. The leap-year cases and the 30-day and 31-day month ends are reached by freezing the registers, writing a time one second before the boundary and re-enabling. The dates used are 2024, 2100, 2000 and 2023. One re-enable is made in the same cycle as a tick, to check that a tick is applied on top of a reload.

// File: rtl/tk_pkg.sv
`timescale 1ns/1ps
package tk_pkg;

  typedef struct packed {
    logic [7:0] cen;
    logic [7:0] yr;
    logic [4:0] mon;
    logic [5:0] dom;
    logic [2:0] dow;
    logic [5:0] hr;
    logic [6:0] mn;
    logic [6:0] sc;
  } tk_time_t;

  localparam logic [3:0] A_SEC  = 4'h0;
  localparam logic [3:0] A_MIN  = 4'h1;
  localparam logic [3:0] A_HOUR = 4'h2;
  localparam logic [3:0] A_DOW  = 4'h3;
  localparam logic [3:0] A_DOM  = 4'h4;
  localparam logic [3:0] A_MON  = 4'h5;
  localparam logic [3:0] A_YEAR = 4'h6;
  localparam logic [3:0] A_CEN  = 4'h7;
  localparam logic [3:0] A_CTRL = 4'hF;
  localparam int unsigned TE_BIT = 7;

  // Add one to a two-digit BCD value (no wrap: the caller decides the limit).
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_step = {v[7:4] + 4'd1, 4'h0};
    else                bcd_step = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Value modulo 4 of a BCD byte: (10*t + o) mod 4 == (2*t + o) mod 4.
  function automatic logic [1:0] bcd_mod4(input logic [7:0] v);
    bcd_mod4 = {v[4], 1'b0} + v[1:0];
  endfunction

  function automatic logic is_leap(input logic [7:0] cen, input logic [7:0] yr);
    if (yr == 8'h00) is_leap = (bcd_mod4(cen) == 2'd0);
    else             is_leap = (bcd_mod4(yr) == 2'd0);
  endfunction

  // Last day of the month, BCD.
  function automatic logic [5:0] month_last(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      month_last = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: month_last = 6'h30;
      default:                    month_last = 6'h31;
    endcase
  endfunction

  // Masked store of one host byte into one field.
  function automatic tk_time_t apply_write(input tk_time_t t, input logic [2:0] sel,
                                           input logic [7:0] d);
    tk_time_t r;
    r = t;
    case (sel)
      3'd0: r.sc  = d[6:0];
      3'd1: r.mn  = d[6:0];
      3'd2: r.hr  = d[5:0];
      3'd3: r.dow = d[2:0];
      3'd4: r.dom = d[5:0];
      3'd5: r.mon = d[4:0];
      3'd6: r.yr  = d;
      default: r.cen = d;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] field_byte(input tk_time_t t, input logic [2:0] sel);
    case (sel)
      3'd0: field_byte = {1'b0, t.sc};
      3'd1: field_byte = {1'b0, t.mn};
      3'd2: field_byte = {2'b00, t.hr};
      3'd3: field_byte = {5'b00000, t.dow};
      3'd4: field_byte = {2'b00, t.dom};
      3'd5: field_byte = {3'b000, t.mon};
      3'd6: field_byte = t.yr;
      default: field_byte = t.cen;
    endcase
  endfunction

endpackage

// File: rtl/tk_counter.sv
`timescale 1ns/1ps
module tk_counter
  import tk_pkg::*;
#(
  parameter tk_time_t RST_VAL = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     reload,
  input  tk_time_t load_val,
  output tk_time_t cnt,
  output logic     hr_wrap,
  output logic     yr_wrap
);

  tk_time_t cnt_q, src, nxt;
  logic sec_wrap, min_wrap, day_wrap, mon_wrap;
  logic [5:0] last_day;

  assign src      = reload ? load_val : cnt_q;
  assign last_day = month_last(src.mon, is_leap(src.cen, src.yr));

  assign sec_wrap = tick     && (src.sc  >= 7'h59);
  assign min_wrap = sec_wrap && (src.mn  >= 7'h59);
  assign hr_wrap  = min_wrap && (src.hr  >= 6'h23);
  assign day_wrap = hr_wrap  && (src.dom >= last_day);
  assign mon_wrap = day_wrap && (src.mon >= 5'h12);
  assign yr_wrap  = mon_wrap && (src.yr  >= 8'h99);

  always_comb begin
    nxt = src;
    if (tick)     nxt.sc  = sec_wrap ? 7'h00 : 7'(bcd_step(8'(src.sc)));
    if (sec_wrap) nxt.mn  = min_wrap ? 7'h00 : 7'(bcd_step(8'(src.mn)));
    if (min_wrap) nxt.hr  = hr_wrap  ? 6'h00 : 6'(bcd_step(8'(src.hr)));
    if (hr_wrap) begin
      nxt.dow = (src.dow >= 3'd7) ? 3'd1 : src.dow + 3'd1;
      nxt.dom = day_wrap ? 6'h01 : 6'(bcd_step(8'(src.dom)));
    end
    if (day_wrap) nxt.mon = mon_wrap ? 5'h01 : 5'(bcd_step(8'(src.mon)));
    if (mon_wrap) nxt.yr  = yr_wrap  ? 8'h00 : bcd_step(src.yr);
    if (yr_wrap)  nxt.cen = (src.cen >= 8'h99) ? 8'h00 : bcd_step(src.cen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= nxt;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tk_snapshot.sv
`timescale 1ns/1ps
module tk_snapshot
  import tk_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter tk_time_t    RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  tk_time_t          cnt,
  output logic              te,
  output tk_time_t          usr,
  output logic              reload
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] NFIELD = ADDR_W'(8);

  logic     te_q, dirty_q;
  tk_time_t usr_q;
  logic     ctrl_wr, field_wr, freeze;

  assign ctrl_wr  = wr_en && (addr == CTRL_A);
  assign field_wr = wr_en && (addr < NFIELD) && !te_q;
  assign freeze   = ctrl_wr && te_q && !wdata[TE_BIT];
  assign reload   = ctrl_wr && !te_q && wdata[TE_BIT] && dirty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_q    <= 1'b1;
      dirty_q <= 1'b0;
      usr_q   <= RST_VAL;
    end else begin
      if (ctrl_wr) te_q <= wdata[TE_BIT];
      if (freeze) begin
        usr_q   <= cnt;
        dirty_q <= 1'b0;
      end else if (field_wr) begin
        usr_q   <= apply_write(usr_q, addr[2:0], wdata);
        dirty_q <= 1'b1;
      end
    end
  end

  assign te  = te_q;
  assign usr = usr_q;

endmodule

// File: rtl/tk_readmux.sv
`timescale 1ns/1ps
module tk_readmux
  import tk_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              te,
  input  tk_time_t          cnt,
  input  tk_time_t          usr,
  output logic [7:0]        rdata
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] NFIELD = ADDR_W'(8);

  tk_time_t view;
  assign view = te ? cnt : usr;

  always_comb begin
    if (addr < NFIELD)       rdata = field_byte(view, addr[2:0]);
    else if (addr == CTRL_A) rdata = {te, 7'b0};
    else                     rdata = 8'h00;
  end

endmodule

// File: rtl/bcd_timekeeper.sv
`timescale 1ns/1ps
module bcd_timekeeper
  import tk_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter logic [7:0]  RST_CEN = 8'h20,
  parameter logic [7:0]  RST_YR  = 8'h00,
  parameter logic [7:0]  RST_MON = 8'h01,
  parameter logic [7:0]  RST_DOM = 8'h01,
  parameter logic [7:0]  RST_DOW = 8'h01,
  parameter logic [7:0]  RST_HR  = 8'h00,
  parameter logic [7:0]  RST_MIN = 8'h00,
  parameter logic [7:0]  RST_SEC = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  localparam tk_time_t RST_VAL = '{cen: RST_CEN, yr: RST_YR, mon: RST_MON[4:0],
                                   dom: RST_DOM[5:0], dow: RST_DOW[2:0],
                                   hr: RST_HR[5:0], mn: RST_MIN[6:0], sc: RST_SEC[6:0]};

  tk_time_t cnt_q, usr_q;
  logic     te_q, reload_ev, hr_wrap, yr_wrap;

  tk_counter #(.RST_VAL(RST_VAL)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload_ev),
    .load_val(usr_q), .cnt(cnt_q), .hr_wrap(hr_wrap), .yr_wrap(yr_wrap)
  );

  tk_snapshot #(.ADDR_W(ADDR_W), .RST_VAL(RST_VAL)) u_snap (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt(cnt_q), .te(te_q), .usr(usr_q), .reload(reload_ev)
  );

  tk_readmux #(.ADDR_W(ADDR_W)) u_rd (
    .addr(addr), .te(te_q), .cnt(cnt_q), .usr(usr_q), .rdata(rdata)
  );

endmodule

// File: rtl/tk_checker.sv
`timescale 1ns/1ps
module tk_checker
  import tk_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              te,
  input tk_time_t          cnt,
  input tk_time_t          usr,
  input logic              reload,
  input logic              hr_wrap,
  input logic              yr_wrap
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(A_CTRL);

  // R2
  sec_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reload && cnt.sc < 7'h59) |=> (cnt.sc != $past(cnt.sc)));

  // R3
  hour_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hr_wrap |=> (cnt.hr == 6'h00 && cnt.mn == 7'h00 && cnt.sc == 7'h00));

  // R6
  year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    yr_wrap |=> (cnt.yr == 8'h00 && cnt.mon == 5'h01 && cnt.dom == 6'h01));

  // R7
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!te && !wr_en) |=> $stable(usr));

  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reload) |=> $stable(cnt));

  // R9
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !tick) |=> (cnt == $past(usr)));

  // R10
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (te && wr_en && addr != CTRL_A) |=> $stable(usr));

endmodule

bind bcd_timekeeper tk_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .te(te_q), .cnt(cnt_q), .usr(usr_q), .reload(reload_ev),
  .hr_wrap(hr_wrap), .yr_wrap(yr_wrap)
);

// File: tb/bcd_timekeeper_test.sv
`timescale 1ns/1ps
module bcd_timekeeper_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  always #4 clk = ~clk;

  bcd_timekeeper #(
    .ADDR_W(4), .RST_CEN(8'h19), .RST_YR(8'h99), .RST_MON(8'h12), .RST_DOM(8'h31),
    .RST_DOW(8'h07), .RST_HR(8'h23), .RST_MIN(8'h59), .RST_SEC(8'h50)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R1";

  // Reference model: binary integers for the live time, bytes for the snapshot.
  int s = 50, m = 59, h = 23, w = 7, d = 31, mo = 12, y = 99, c = 19;
  logic [7:0] sb [8];
  bit te_m = 1;
  bit dirty_m = 0;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int days_in(input int mon, input int full);
    bit leap;
    leap = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
    if (mon == 2) return leap ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] field_mask(input int a);
    case (a)
      0, 1: return 8'h7F;
      2, 4: return 8'h3F;
      3: return 8'h07;
      5: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] live_byte(input int a);
    case (a)
      0: return to_bcd(s);
      1: return to_bcd(m);
      2: return to_bcd(h);
      3: return to_bcd(w);
      4: return to_bcd(d);
      5: return to_bcd(mo);
      6: return to_bcd(y);
      default: return to_bcd(c);
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    if (a < 8) return te_m ? live_byte(a) : sb[a];
    if (a == 15) return te_m ? 8'h80 : 8'h00;
    return 8'h00;
  endfunction

  task automatic advance();
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0;
          w = (w == 7) ? 1 : w + 1;
          d++;
          if (d > days_in(mo, c * 100 + y)) begin
            d = 1; mo++;
            if (mo == 13) begin
              mo = 1; y++;
              if (y == 100) begin y = 0; c = (c + 1) % 100; end
            end
          end
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      s = 50; m = 59; h = 23; w = 7; d = 31; mo = 12; y = 99; c = 19;
      te_m = 1; dirty_m = 0;
    end else begin
      bit ctl, frz, rld;
      int a;
      a   = int'(addr);
      ctl = wr_en && (a == 15);
      frz = ctl && te_m && !wdata[7];
      rld = ctl && !te_m && wdata[7] && dirty_m;
      if (frz) begin
        for (int i = 0; i < 8; i++) sb[i] = live_byte(i);
        dirty_m = 0;
      end
      if (rld) begin
        s = from_bcd(sb[0]); m = from_bcd(sb[1]); h = from_bcd(sb[2]);
        w = from_bcd(sb[3]); d = from_bcd(sb[4]); mo = from_bcd(sb[5]);
        y = from_bcd(sb[6]); c = from_bcd(sb[7]);
      end
      if (tick) advance();
      if (wr_en && a < 8 && !te_m) begin
        sb[a] = wdata & field_mask(a);
        dirty_m = 1;
      end
      if (ctl) te_m = wdata[7];
    end
  end

  task automatic check(input string t, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s addr=%0h actual=%02h expected=%02h at %0t", t, addr, got, exp, $time);
    end
  endtask

  // Compare every cycle, before the next rising edge, after inputs settle.
  always begin
    @(negedge clk);
    #3;
    if (!done) check(tag, rdata, exp_rd(int'(addr)));
  end

  int rot [10] = '{0, 1, 2, 3, 4, 5, 6, 7, 15, 9};
  int ri = 0;

  task automatic cyc(input bit tk, input bit w_e, input int a, input int dv);
    @(negedge clk);
    tick = tk; wr_en = w_e; addr = a[3:0]; wdata = dv[7:0];
  endtask

  task automatic idle(input int n, input int per);
    for (int i = 0; i < n; i++) begin
      cyc((per != 0) && (i % per == 0), 1'b0, rot[ri], 0);
      ri = (ri + 1) % 10;
    end
  endtask

  task automatic set_time(input int cc, input int yy, input int mm, input int dd,
                          input int ww, input int hh, input int mi, input int ss);
    cyc(1'b0, 1'b1, 15, 8'h00);
    cyc(1'b0, 1'b1, 7, to_bcd(cc));
    cyc(1'b0, 1'b1, 6, to_bcd(yy));
    cyc(1'b0, 1'b1, 5, to_bcd(mm));
    cyc(1'b0, 1'b1, 4, to_bcd(dd));
    cyc(1'b0, 1'b1, 3, to_bcd(ww));
    cyc(1'b0, 1'b1, 2, to_bcd(hh));
    cyc(1'b0, 1'b1, 1, to_bcd(mi));
    cyc(1'b0, 1'b1, 0, to_bcd(ss));
    cyc(1'b0, 1'b1, 15, 8'h80);
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    idle(4, 0);
    rst_n = 1'b1;
    idle(12, 0);
    // R6 with R2, R3 and R4: the first ten ticks roll every field
    tag = "R6";
    idle(40, 1);
    tag = "R2";
    idle(300, 2);
    // R7: freeze while ticking, then re-enable with no write
    tag = "R7";
    cyc(1'b1, 1'b1, 15, 8'h00);
    idle(40, 1);
    cyc(1'b1, 1'b1, 15, 8'h80);
    idle(20, 1);
    // R10: writes while transfer enable is set have no effect
    tag = "R10";
    cyc(1'b0, 1'b1, 0, 8'h33);
    cyc(1'b0, 1'b1, 5, 8'h07);
    cyc(1'b0, 1'b1, 12, 8'hFF);
    idle(12, 0);
    // R8: masked field writes while frozen
    tag = "R8";
    cyc(1'b1, 1'b1, 15, 8'h00);
    cyc(1'b1, 1'b1, 5, 8'hE2);
    cyc(1'b0, 1'b0, 5, 0);
    cyc(1'b1, 1'b1, 0, 8'hD9);
    cyc(1'b0, 1'b0, 0, 0);
    cyc(1'b0, 1'b1, 3, 8'hFB);
    cyc(1'b0, 1'b0, 3, 0);
    cyc(1'b1, 1'b1, 7, 8'h20);
    cyc(1'b0, 1'b1, 6, 8'h24);
    cyc(1'b0, 1'b1, 4, 8'h28);
    cyc(1'b0, 1'b1, 2, 8'h23);
    cyc(1'b0, 1'b1, 1, 8'h59);
    cyc(1'b0, 1'b1, 0, 8'h59);
    cyc(1'b0, 1'b1, 3, 8'h03);
    idle(20, 3);
    // R9: re-enable in the same cycle as a tick -> 2024-02-29 00:00:00
    tag = "R9";
    cyc(1'b1, 1'b1, 15, 8'h80);
    idle(12, 0);
    // R5: leap-day handling
    tag = "R5";
    set_time(20, 24, 2, 29, 4, 23, 59, 59); idle(1, 1); idle(10, 0);
    set_time(21, 0, 2, 28, 7, 23, 59, 59);  idle(1, 1); idle(10, 0);
    set_time(20, 0, 2, 28, 1, 23, 59, 59);  idle(1, 1); idle(10, 0);
    set_time(20, 23, 2, 28, 2, 23, 59, 59); idle(1, 1); idle(10, 0);
    // R4: 30-day and 31-day month ends
    tag = "R4";
    set_time(20, 23, 4, 30, 7, 23, 59, 59); idle(1, 1); idle(10, 0);
    set_time(20, 23, 1, 31, 2, 23, 59, 59); idle(1, 1); idle(10, 0);
    // R3: hour and day-of-week wrap
    tag = "R3";
    set_time(20, 23, 6, 10, 7, 23, 59, 58); idle(30, 1);
    // R6: century wrap 99 -> 00
    tag = "R6";
    set_time(99, 99, 12, 31, 5, 23, 59, 59); idle(1, 1); idle(10, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule